// File: doc/BRIEF.md
# Prefix-Opcode Bank Bit Sequencer

This block lets an 8-bit processor with a 64K address space reach 128K of memory. Memory is split into two 64K banks, and the block drives the extra address line `a16` one bus cycle at a time. It watches opcode fetches. A fetch whose byte has the low three bits `011` is a prefix, an opcode the processor does not otherwise define. On a prefix, the block takes an 8-bit timing pattern from a 32-entry table. The table is indexed by the upper five opcode bits. The block loads that pattern into a shift register, which then presents one bit per bus cycle on `a16`.

Each table entry holds a single one at the position that lines up with the operand read or write of the instruction that follows. The alternate bank is therefore selected for exactly that one access. A prefix carries no knowledge of addressing mode. Software picks the prefix code whose bit offset matches the timing of the instruction it precedes. The register fills with zeros behind the pattern, so `a16` falls back to bank 0 once the pattern is used up.

Top module: `bank_bit_seq`

## Requirements
- R1: After reset, `a16` is 0 and stays 0 until a prefix is accepted.
- R2: A prefix is accepted on a clock edge where `bus_ce`, `sync` and `data_in[2:0] == 3'b011` are all high. An opcode fetch with any other low three bits is not a prefix, and `a16` stays 0 while the block is idle.
- R3: The pattern for an accepted prefix is entry `data_in[7:3]` of the parameter `PAT_TABLE`. Entry i occupies bits `[i*8 +: 8]`.
- R4: The pattern is output MSB first. In the k-th bus cycle after the prefix fetch (k = 1..8), `a16` equals `pattern[8-k]`.
- R5: Zeros are shifted in behind the pattern. From the 9th bus cycle after a prefix until the next prefix, `a16` is 0.
- R6: While `bus_ce` is low, `a16` and the pattern position hold unchanged, whatever `sync` and `data_in` do.
- R7: A prefix accepted while a pattern is still shifting discards the rest of that pattern and restarts output at bit 7 of the new pattern.
- R8: A byte matching `xxxxx011` with `sync` low (an operand or data transfer) is not a prefix and does not disturb the running pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ce | input | 1 | Clock enable, high for one clock per bus cycle |
| sync | input | 1 | High during an opcode fetch cycle |
| data_in | input | 8 | Data bus byte of the current bus cycle |
| a16 | output | 1 | Bank select address bit (0 = bank 0, 1 = bank 1) |

## Verification
Two cases are hard to reach from the ports:
- A reload that arrives while a pattern is only partly shifted out.
- A stall that falls between two bits of a pattern.

To reach them, the bench sweeps every prefix code. It uses a table of its own, in which every entry has several distinct bits, so that a wrong shift direction or a wrong cut-over point changes the observed sequence. In the same sweep it injects second prefixes at every offset from 1 to 7 cycles, and it inserts stalled cycles with prefix-shaped bytes on the bus. Expected values are computed arithmetically from the table formula.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  localparam int DEF_OP_W  = 8;
  localparam int DEF_TAG_W = 3;
  localparam int DEF_PAT_W = 8;
  localparam int DEF_TBL_N = 1 << (DEF_OP_W - DEF_TAG_W);

  // Default table: entry i selects the alternate bank in cycle (i mod 8)+1.
  function automatic logic [DEF_TBL_N*DEF_PAT_W-1:0] default_table();
    logic [DEF_TBL_N*DEF_PAT_W-1:0] t;
    t = '0;
    for (int i = 0; i < DEF_TBL_N; i++) begin
      t[i*DEF_PAT_W + (DEF_PAT_W - 1 - (i % DEF_PAT_W))] = 1'b1;
    end
    return t;
  endfunction

  // True when the low tag field of an opcode equals the prefix tag.
  function automatic logic tag_is(input logic [DEF_TAG_W-1:0] low,
                                  input logic [DEF_TAG_W-1:0] tag);
    return low == tag;
  endfunction
endpackage

// File: rtl/bbs_prefix_detect.sv
module bbs_prefix_detect #(
  parameter int OP_W  = 8,
  parameter int TAG_W = 3,
  parameter logic [TAG_W-1:0] TAG = 3'b011,
  localparam int IDX_W = OP_W - TAG_W
) (
  input  logic             bus_ce,
  input  logic             sync,
  input  logic [OP_W-1:0]  data_in,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic tag_ok;

  always_comb begin
    tag_ok = (data_in[TAG_W-1:0] == TAG);
    hit    = bus_ce && sync && tag_ok;
    idx    = data_in[OP_W-1:TAG_W];
  end
endmodule

// File: rtl/bbs_pattern_rom.sv
module bbs_pattern_rom #(
  parameter int IDX_W = 5,
  parameter int PAT_W = 8,
  localparam int TBL_N = 1 << IDX_W,
  parameter logic [TBL_N*PAT_W-1:0] TABLE = '0
) (
  input  logic [IDX_W-1:0] idx,
  output logic [PAT_W-1:0] word
);
  logic [PAT_W-1:0] entries [TBL_N];

  for (genvar g = 0; g < TBL_N; g++) begin : g_entry
    assign entries[g] = TABLE[g*PAT_W +: PAT_W];
  end

  assign word = entries[idx];
endmodule

// File: rtl/bbs_shifter.sv
module bbs_shifter #(
  parameter int PAT_W = 8,
  localparam int CNT_W = $clog2(PAT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [PAT_W-1:0] load_word,
  output logic             bit_out
);
  logic [PAT_W-1:0] sreg;
  logic             shift_now;

  assign shift_now = step && !load;

  always_ff @(posedge clk) begin
    if (!rst_n)         sreg <= '0;
    else if (load)      sreg <= load_word;
    else if (shift_now) sreg <= {sreg[PAT_W-2:0], 1'b0};
  end

  assign bit_out = sreg[PAT_W-1];

  // Checker-only count of bus cycles since the last load (saturating).
  logic [CNT_W-1:0] since_load;
  always_ff @(posedge clk) begin
    if (!rst_n)    since_load <= CNT_W'(PAT_W);
    else if (load) since_load <= '0;
    else if (step && since_load != CNT_W'(PAT_W)) since_load <= since_load + 1'b1;
  end

  // R5: once a pattern is used up, the output stays in bank 0
  p_drained_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_load == CNT_W'(PAT_W)) |-> (bit_out == 1'b0));

  // R5: zero fill behind the pattern
  p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_now |=> (sreg[0] == 1'b0));

  // R4: MSB-first advance by one position per bus cycle
  p_shift_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_now |=> (sreg[PAT_W-1:1] == $past(sreg[PAT_W-2:0])));

  // R6: stalled bus cycles freeze the pattern
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(sreg));
endmodule

// File: rtl/bank_bit_seq.sv
module bank_bit_seq #(
  parameter int OP_W  = bbs_pkg::DEF_OP_W,
  parameter int TAG_W = bbs_pkg::DEF_TAG_W,
  parameter int PAT_W = bbs_pkg::DEF_PAT_W,
  parameter logic [TAG_W-1:0] PREFIX_TAG = 3'b011,
  parameter logic [(1<<(OP_W-TAG_W))*PAT_W-1:0] PAT_TABLE = bbs_pkg::default_table()
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_ce,
  input  logic            sync,
  input  logic [OP_W-1:0] data_in,
  output logic            a16
);
  localparam int IDX_W = OP_W - TAG_W;

  logic             prefix_hit;
  logic [IDX_W-1:0] prefix_idx;
  logic [PAT_W-1:0] pattern_word;

  bbs_prefix_detect #(.OP_W(OP_W), .TAG_W(TAG_W), .TAG(PREFIX_TAG)) u_detect (
    .bus_ce (bus_ce),
    .sync   (sync),
    .data_in(data_in),
    .hit    (prefix_hit),
    .idx    (prefix_idx)
  );

  bbs_pattern_rom #(.IDX_W(IDX_W), .PAT_W(PAT_W), .TABLE(PAT_TABLE)) u_rom (
    .idx (prefix_idx),
    .word(pattern_word)
  );

  bbs_shifter #(.PAT_W(PAT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (prefix_hit),
    .step     (bus_ce),
    .load_word(pattern_word),
    .bit_out  (a16)
  );

  // R3/R4: first bit after an accepted prefix comes from the indexed table entry
  p_first_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ce && sync && data_in[TAG_W-1:0] == PREFIX_TAG) |=>
      (a16 == PAT_TABLE[$past(data_in[OP_W-1:TAG_W])*PAT_W + PAT_W - 1]));

  // R8: a prefix-shaped byte without sync is not a load
  p_no_sync_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |-> !prefix_hit);
endmodule

// File: tb/sim_bank_bit_seq.sv
module sim_bank_bit_seq;
  localparam int N = 32;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 7) ^ (i << 3) ^ 8'h5A);
  endfunction

  function automatic logic [N*8-1:0] mk_table();
    logic [N*8-1:0] t;
    for (int i = 0; i < N; i++) t[i*8 +: 8] = pat(i);
    return t;
  endfunction

  localparam logic [N*8-1:0] TBL = mk_table();

  logic clk = 0, rst_n = 0, bus_ce = 0, sync = 0;
  logic [7:0] data_in = 0;
  logic a16;
  int checks = 0, fails = 0;

  bank_bit_seq #(.PAT_TABLE(TBL)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .sync(sync),
    .data_in(data_in), .a16(a16)
  );

  always #5 clk = ~clk;

  task automatic step(input logic ce, input logic sy, input logic [7:0] d);
    bus_ce = ce; sync = sy; data_in = d;
    @(posedge clk); #2;
  endtask

  task automatic chk(input logic exp, input string req);
    checks++;
    if (a16 !== exp) begin
      fails++;
      $display("FAIL %s: a16=%b expected %b at %0t", req, a16, exp, $time);
    end
  endtask

  // Non-prefix filler byte (low bits 000).
  function automatic logic [7:0] filler(input int k);
    return 8'((k * 8) & 8'hF8);
  endfunction

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(0, 0, 0); step(0, 0, 0);
    chk(1'b0, "R1 reset");
    rst_n = 1;
    step(1, 0, 8'h00);
    chk(1'b0, "R1 idle after reset");

    // R2: every non-prefix opcode keeps a16 at 0 from idle
    for (int op = 0; op < 256; op++) begin
      if (op[2:0] != 3'b011) begin
        step(1, 1, 8'(op));
        chk(1'b0, "R2 non-prefix opcode");
      end
    end

    // R3/R4/R5/R8: every prefix, full sequence, operand bytes shaped like prefixes
    for (int i = 0; i < N; i++) begin
      logic [7:0] p;
      p = pat(i);
      step(1, 1, {5'(i), 3'b011});
      chk(p[7], "R3 R4 first bit");
      for (int k = 1; k < 8; k++) begin
        step(1, 0, {5'(k), 3'b011});
        chk(p[7-k], "R4 R8 shifted bit");
      end
      for (int k = 0; k < 3; k++) begin
        step(1, (k == 1), filler(k + i));
        chk(1'b0, "R5 zero after pattern");
      end
    end

    // R7: reload at every offset
    for (int off = 1; off < 8; off++) begin
      int a, b;
      logic [7:0] pb;
      a = off; b = 31 - off;
      pb = pat(b);
      step(1, 1, {5'(a), 3'b011});
      for (int k = 1; k < off; k++) step(1, 0, filler(k));
      step(1, 1, {5'(b), 3'b011});
      chk(pb[7], "R7 reload first bit");
      for (int k = 1; k < 8; k++) begin
        step(1, 0, filler(k));
        chk(pb[7-k], "R7 reload sequence");
      end
      step(1, 0, filler(0));
      chk(1'b0, "R7 R5 zero after reload");
    end

    // R6: stalls between every bit, with prefix bytes and sync on the bus
    for (int i = 0; i < N; i += 5) begin
      logic [7:0] p;
      p = pat(i);
      step(1, 1, {5'(i), 3'b011});
      for (int k = 0; k < 8; k++) begin
        step(0, 1, {5'(k + 3), 3'b011});
        chk(p[7-k], "R6 stall hold");
        step(0, 0, 8'hFF);
        chk(p[7-k], "R6 stall hold");
        if (k < 7) begin
          step(1, 0, filler(k));
          chk(p[6-k], "R6 resume");
        end
      end
      step(1, 0, filler(1));
      chk(1'b0, "R6 R5 drained");
    end

    // R1: reset mid-pattern clears a16
    step(1, 1, {5'd4, 3'b011});
    rst_n = 0;
    step(1, 0, 8'h00);
    chk(1'b0, "R1 reset mid-pattern");
    rst_n = 1;
    step(1, 0, 8'h00);
    chk(1'b0, "R1 idle after second reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule